// File: doc/BRIEF.md
# Lockable Translation Buffer with Pinned Entries

This block is a small, fully associative address translation buffer for a device-side memory management unit. Each slot holds a tag (virtual page, two-bit page-size code, valid flag, pinned flag) and a data part (physical page and attribute bits). A lock state made of two counters, `lk_base` and `lk_victim`, governs replacement. Slots whose index is below `lk_base` are pinned: a normal load never picks them. A load marked as pinned is written at index `lk_base`, and the base then moves up by one.

Software, or a table walker sitting beside the block, drives four single-cycle operations: load, invalidate by address, global flush and read by index. A combinational lookup port translates an address at any time. Each operation decodes to one named operation state, `OP_IDLE`, `OP_FLUSH`, `OP_LOAD`, `OP_INVAL` or `OP_READ`, and completes in the cycle it is chosen. There are no multi-cycle states. Every transition therefore goes from the decoded operation back to `OP_IDLE` at the next edge. Load and read results are registered and appear one cycle after the request.

Top module: `lockable_tlb`

## Requirements
- R1: After reset every slot is invalid, `lk_base` and `lk_victim` are 0 and a lookup misses.
- R2: A load with `ld_keep`=1 is written at slot `lk_base`, even if that slot holds a valid entry. `lk_base` then increases by one.
- R3: When `lk_base` equals the entry count (8 by default), every load is refused: `ld_busy` pulses, `ld_ok` stays low, and `lk_base` and `lk_victim` do not change.
- R4: A load with `ld_keep`=0 is written into the lowest-indexed invalid slot whose index is at least `lk_base`. That slot index appears on `ld_slot`. If no such slot exists, `ld_full` pulses and nothing changes.
- R5: After a successful load, `lk_victim` becomes the written slot plus one. If that value equals the entry count, `lk_victim` takes the updated `lk_base` instead of zero.
- R6: Size code 0 selects 1 MB pages (20 offset bits), 1 selects 64 KB (16 bits), 2 selects 4 KB (12 bits) and 3 selects 16 MB (24 bits). Virtual and physical addresses are stored with their offset bits cleared.
- R7: A lookup hits when a valid slot's virtual page equals `lu_va` above that slot's offset bits. `lu_pa` is the stored physical page ORed with the offset bits of `lu_va`, and `lu_attr` is the slot's attribute value.
- R8: Invalidate by address clears every valid slot, pinned or not, whose page contains `inv_va`. It leaves the other slots and the lock counters unchanged.
- R9: A global flush invalidates all slots and sets `lk_base` and `lk_victim` to 0.
- R10: A read by index sets `lk_victim` to `rd_idx`. One cycle later it pulses `rd_ack` and presents that slot's valid flag, pinned flag, size code, stored virtual page, physical page and attributes.
- R11: When several requests arrive in one cycle, flush beats load, load beats invalidate, and invalidate beats read. A request that loses is dropped with no effect; a dropped read gives no `rd_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_req | input | 1 | Invalidate all slots and clear the lock counters |
| ld_req | input | 1 | Load request |
| ld_keep | input | 1 | Load as a pinned entry |
| ld_size | input | 2 | Page-size code of the load |
| ld_va | input | 32 | Virtual address of the load |
| ld_pa | input | 32 | Physical address of the load |
| ld_attr | input | ATTR_W | Attribute bits of the load |
| ld_ok | output | 1 | Load accepted (one-cycle pulse) |
| ld_busy | output | 1 | Load refused because all slots are pinned |
| ld_full | output | 1 | Load refused because no free slot exists |
| ld_slot | output | IDX_W | Slot written by the accepted load |
| inv_req | input | 1 | Invalidate-by-address request |
| inv_va | input | 32 | Address to invalidate |
| rd_req | input | 1 | Read-by-index request |
| rd_idx | input | IDX_W | Slot to read |
| rd_ack | output | 1 | Read data valid (one-cycle pulse) |
| rd_valid | output | 1 | Valid flag of the slot read |
| rd_keep | output | 1 | Pinned flag of the slot read |
| rd_size | output | 2 | Size code of the slot read |
| rd_va | output | 32 | Stored virtual page of the slot read |
| rd_pa | output | 32 | Stored physical page of the slot read |
| rd_attr | output | ATTR_W | Attributes of the slot read |
| lk_base | output | CNT_W | Count of pinned slots (lock base) |
| lk_victim | output | CNT_W | Victim pointer |
| lu_va | input | 32 | Lookup address |
| lu_hit | output | 1 | Lookup hit |
| lu_pa | output | 32 | Translated address |
| lu_attr | output | ATTR_W | Attributes of the hit slot |

## Verification
The assertions assume that the loaded translations never overlap. At most one valid slot may cover any lookup address, and one check flags two matches at once. They also assume that requests are not raised while reset is active. The stimulus keeps every loaded page in its own distinct region, so no two of them overlap. It raises requests only after reset is released and holds each one for exactly one clock. When the bench needs two live translations that cover the same region, it places them in separate scenarios with a flush between them.

// File: rtl/tlb_lock_pkg.sv
package tlb_lock_pkg;

    localparam int ADDR_W = 32;
    typedef logic [ADDR_W-1:0] addr_t;

    // page-size code held in each tag
    typedef enum logic [1:0] {
        PG_1M  = 2'd0,
        PG_64K = 2'd1,
        PG_4K  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    // operation chosen for the current cycle
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_FLUSH,
        OP_LOAD,
        OP_INVAL,
        OP_READ
    } op_e;

    // mask of the in-page offset bits for a size code
    function automatic addr_t off_mask(input pg_size_e sz);
        unique case (sz)
            PG_1M:   off_mask = addr_t'(32'h000F_FFFF);
            PG_64K:  off_mask = addr_t'(32'h0000_FFFF);
            PG_4K:   off_mask = addr_t'(32'h0000_0FFF);
            default: off_mask = addr_t'(32'h00FF_FFFF);
        endcase
    endfunction

endpackage

// File: rtl/tlb_range_cmp.sv
module tlb_range_cmp
    import tlb_lock_pkg::*;
(
    input  logic  valid,
    input  addr_t tag_va,
    input  logic [1:0] size,
    input  addr_t probe,
    output logic  match
);
    addr_t page_bits;

    always_comb begin
        page_bits = ~off_mask(pg_size_e'(size));
        match     = valid && (((probe ^ tag_va) & page_bits) == '0);
    end
endmodule

// File: rtl/tlb_slot_pick.sv
module tlb_slot_pick #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int CNT_W = $clog2(ENTRIES + 1)
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [CNT_W-1:0]   base,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    // lowest invalid slot at or above the lock base
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i] && (CNT_W'(i) >= base)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lockable_tlb.sv
module lockable_tlb
    import tlb_lock_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ATTR_W  = 4,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int CNT_W = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_req,
    input  logic              ld_req,
    input  logic              ld_keep,
    input  logic [1:0]        ld_size,
    input  logic [31:0]       ld_va,
    input  logic [31:0]       ld_pa,
    input  logic [ATTR_W-1:0] ld_attr,
    output logic              ld_ok,
    output logic              ld_busy,
    output logic              ld_full,
    output logic [IDX_W-1:0]  ld_slot,
    input  logic              inv_req,
    input  logic [31:0]       inv_va,
    input  logic              rd_req,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_ack,
    output logic              rd_valid,
    output logic              rd_keep,
    output logic [1:0]        rd_size,
    output logic [31:0]       rd_va,
    output logic [31:0]       rd_pa,
    output logic [ATTR_W-1:0] rd_attr,
    output logic [CNT_W-1:0]  lk_base,
    output logic [CNT_W-1:0]  lk_victim,
    input  logic [31:0]       lu_va,
    output logic              lu_hit,
    output logic [31:0]       lu_pa,
    output logic [ATTR_W-1:0] lu_attr
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ENTRIES);

    // slot storage
    logic [ENTRIES-1:0] e_valid, e_keep;
    addr_t              e_va   [ENTRIES];
    addr_t              e_pa   [ENTRIES];
    logic [1:0]         e_size [ENTRIES];
    logic [ATTR_W-1:0]  e_attr [ENTRIES];

    logic [CNT_W-1:0] base_q, victim_q;
    logic [ENTRIES-1:0] lu_match, inv_match;

    // per-slot comparators for lookup and invalidate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        tlb_range_cmp u_lu (
            .valid(e_valid[g]), .tag_va(e_va[g]), .size(e_size[g]),
            .probe(lu_va), .match(lu_match[g])
        );
        tlb_range_cmp u_inv (
            .valid(e_valid[g]), .tag_va(e_va[g]), .size(e_size[g]),
            .probe(inv_va), .match(inv_match[g])
        );
    end

    // free-slot search
    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    tlb_slot_pick #(.ENTRIES(ENTRIES)) u_pick (
        .valid(e_valid), .base(base_q), .found(free_found), .idx(free_idx)
    );

    // operation decode, fixed priority
    op_e op;
    always_comb begin
        if (flush_req)    op = OP_FLUSH;
        else if (ld_req)  op = OP_LOAD;
        else if (inv_req) op = OP_INVAL;
        else if (rd_req)  op = OP_READ;
        else              op = OP_IDLE;
    end

    // load placement and lock update
    logic             all_pinned, ld_can;
    logic [IDX_W-1:0] tgt_idx;
    logic [CNT_W-1:0] base_after, slot_plus, victim_after;
    addr_t            ld_mask;
    always_comb begin
        all_pinned   = (base_q == FULL_CNT);
        tgt_idx      = ld_keep ? base_q[IDX_W-1:0] : free_idx;
        ld_can       = !all_pinned && (ld_keep || free_found);
        base_after   = ld_keep ? base_q + 1'b1 : base_q;
        slot_plus    = CNT_W'(tgt_idx) + 1'b1;
        victim_after = (slot_plus == FULL_CNT) ? base_after : slot_plus;
        ld_mask      = ~off_mask(pg_size_e'(ld_size));
    end

    // control state: valid bits, lock counters, result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_valid  <= '0;
            e_keep   <= '0;
            base_q   <= '0;
            victim_q <= '0;
            ld_ok    <= 1'b0;
            ld_busy  <= 1'b0;
            ld_full  <= 1'b0;
            ld_slot  <= '0;
            rd_ack   <= 1'b0;
        end else begin
            ld_ok   <= 1'b0;
            ld_busy <= 1'b0;
            ld_full <= 1'b0;
            rd_ack  <= 1'b0;
            unique case (op)
                OP_FLUSH: begin
                    e_valid  <= '0;
                    e_keep   <= '0;
                    base_q   <= '0;
                    victim_q <= '0;
                end
                OP_LOAD: begin
                    if (all_pinned) begin
                        ld_busy <= 1'b1;
                    end else if (!ld_can) begin
                        ld_full <= 1'b1;
                    end else begin
                        e_valid[tgt_idx] <= 1'b1;
                        e_keep[tgt_idx]  <= ld_keep;
                        base_q           <= base_after;
                        victim_q         <= victim_after;
                        ld_ok            <= 1'b1;
                        ld_slot          <= tgt_idx;
                    end
                end
                OP_INVAL: begin
                    e_valid <= e_valid & ~inv_match;
                    e_keep  <= e_keep & ~inv_match;
                end
                OP_READ: begin
                    victim_q <= CNT_W'(rd_idx);
                    rd_ack   <= 1'b1;
                end
                OP_IDLE: ;
                default: ;
            endcase
        end
    end

    // slot payload and read-back registers (no reset needed)
    always_ff @(posedge clk) begin
        if (op == OP_LOAD && ld_can) begin
            e_va[tgt_idx]   <= ld_va & ld_mask;
            e_pa[tgt_idx]   <= ld_pa & ld_mask;
            e_size[tgt_idx] <= ld_size;
            e_attr[tgt_idx] <= ld_attr;
        end
        if (op == OP_READ) begin
            rd_valid <= e_valid[rd_idx];
            rd_keep  <= e_keep[rd_idx];
            rd_size  <= e_size[rd_idx];
            rd_va    <= e_va[rd_idx];
            rd_pa    <= e_pa[rd_idx];
            rd_attr  <= e_attr[rd_idx];
        end
    end

    // combinational lookup, lowest index wins
    always_comb begin
        lu_hit  = 1'b0;
        lu_pa   = '0;
        lu_attr = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lu_match[i]) begin
                lu_hit  = 1'b1;
                lu_pa   = e_pa[i] | (lu_va & off_mask(pg_size_e'(e_size[i])));
                lu_attr = e_attr[i];
            end
        end
    end

    assign lk_base   = base_q;
    assign lk_victim = victim_q;

    // R2: a pinned load moves the base up by exactly one
    a_r2_base_step: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ok && $past(ld_keep) |-> lk_base == $past(lk_base) + 1'b1);

    // R3: a refused load leaves the lock untouched while all slots are pinned
    a_r3_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ld_busy |-> lk_base == FULL_CNT && $stable(lk_base) && $stable(lk_victim));

    // R4: an unpinned load never lands below the base
    a_r4_slot_above_base: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ok && !$past(ld_keep) |-> CNT_W'(ld_slot) >= $past(lk_base));

    // R5: after a load the victim lies between base and entry count
    a_r5_victim_range: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ok |-> lk_victim >= lk_base && lk_victim <= FULL_CNT);

    // R7: non-overlapping translations give at most one match
    a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lu_match));

    // R9: flush empties the buffer and clears the lock
    a_r9_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush_req) |-> lk_base == '0 && lk_victim == '0 && !lu_hit);

    // R10: a read points the victim at the slot read
    a_r10_read_victim: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> lk_victim == CNT_W'($past(rd_idx)));

    // R3/R4: only one load outcome per cycle
    a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_ok, ld_busy, ld_full}));
endmodule

// File: tb/sim_lockable_tlb.sv
`timescale 1ns/1ps
module sim_lockable_tlb;
    localparam int ENTRIES = 8;
    localparam int ATTR_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        flush_req = 0, ld_req = 0, ld_keep = 0, inv_req = 0, rd_req = 0;
    logic [1:0]  ld_size = 0;
    logic [31:0] ld_va = 0, ld_pa = 0, inv_va = 0, lu_va = 0;
    logic [3:0]  ld_attr = 0;
    logic [2:0]  rd_idx = 0;
    logic        ld_ok, ld_busy, ld_full, rd_ack, rd_valid, rd_keep, lu_hit;
    logic [2:0]  ld_slot;
    logic [1:0]  rd_size;
    logic [31:0] rd_va, rd_pa, lu_pa;
    logic [3:0]  rd_attr, lu_attr;
    logic [3:0]  lk_base, lk_victim;

    lockable_tlb #(.ENTRIES(ENTRIES), .ATTR_W(ATTR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .flush_req(flush_req),
        .ld_req(ld_req), .ld_keep(ld_keep), .ld_size(ld_size), .ld_va(ld_va),
        .ld_pa(ld_pa), .ld_attr(ld_attr), .ld_ok(ld_ok), .ld_busy(ld_busy),
        .ld_full(ld_full), .ld_slot(ld_slot), .inv_req(inv_req), .inv_va(inv_va),
        .rd_req(rd_req), .rd_idx(rd_idx), .rd_ack(rd_ack), .rd_valid(rd_valid),
        .rd_keep(rd_keep), .rd_size(rd_size), .rd_va(rd_va), .rd_pa(rd_pa),
        .rd_attr(rd_attr), .lk_base(lk_base), .lk_victim(lk_victim),
        .lu_va(lu_va), .lu_hit(lu_hit), .lu_pa(lu_pa), .lu_attr(lu_attr)
    );

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: requests set beforehand take effect, results sampled 1 ns later
    task automatic tick();
        @(posedge clk);
        #1;
        flush_req = 0; ld_req = 0; inv_req = 0; rd_req = 0;
    endtask

    task automatic load(logic keep, logic [1:0] sz, logic [31:0] va,
                        logic [31:0] pa, logic [3:0] at);
        ld_req = 1; ld_keep = keep; ld_size = sz; ld_va = va; ld_pa = pa; ld_attr = at;
        tick();
    endtask

    task automatic flush();
        flush_req = 1;
        tick();
    endtask

    task automatic look(string req, logic [31:0] va, logic hit, logic [31:0] pa);
        lu_va = va;
        #1;
        check(req, lu_hit, hit);
        if (hit) check(req, lu_pa, pa);
    endtask

    task automatic t_reset();
        check("R1 base", lk_base, 0);
        check("R1 victim", lk_victim, 0);
        look("R1 lookup miss", 32'h1234_5678, 0, 0);
    endtask

    task automatic t_sizes();
        load(0, 2'd0, 32'h1230_0000, 32'h8000_0000, 4'h3);
        check("R4 slot0", {ld_ok, ld_slot}, {1'b1, 3'd0});
        check("R5 victim1", lk_victim, 1);
        load(0, 2'd2, 32'h0000_5000, 32'h0009_9000, 4'h5);
        check("R4 slot1", ld_slot, 1);
        load(0, 2'd1, 32'h0002_0000, 32'h0070_0000, 4'h6);
        check("R4 slot2", ld_slot, 2);
        load(0, 2'd3, 32'h0500_1234, 32'h2000_0000, 4'h7);
        check("R5 victim4", lk_victim, 4);
        look("R6 R7 1MB", 32'h1234_5678, 1, 32'h8004_5678);
        check("R7 attr", lu_attr, 4'h3);
        look("R6 R7 4KB", 32'h0000_5ABC, 1, 32'h0009_9ABC);
        look("R6 R7 4KB miss", 32'h0000_6000, 0, 0);
        look("R6 R7 64KB", 32'h0002_F123, 1, 32'h0070_F123);
        look("R6 R7 16MB", 32'h05AB_CDEF, 1, 32'h20AB_CDEF);
        rd_req = 1; rd_idx = 3;
        tick();
        check("R10 ack", rd_ack, 1);
        check("R10 va masked", rd_va, 32'h0500_0000);
        check("R10 fields", {rd_valid, rd_keep, rd_size, rd_attr}, {1'b1, 1'b0, 2'd3, 4'h7});
        check("R10 victim", lk_victim, 3);
    endtask

    task automatic t_inval();
        inv_req = 1; inv_va = 32'h0000_5FFF;
        tick();
        look("R8 cleared", 32'h0000_5ABC, 0, 0);
        look("R8 other kept", 32'h1234_5678, 1, 32'h8004_5678);
        check("R8 lock kept", {lk_base, lk_victim}, {4'd0, 4'd3});
        load(0, 2'd2, 32'h0000_8000, 32'h0001_1000, 4'h1);
        check("R4 refill lowest", ld_slot, 1);
        check("R5 victim slot+1", lk_victim, 2);
    endtask

    task automatic t_pinned();
        flush();
        check("R9 flush lock", {lk_base, lk_victim}, 8'h00);
        look("R9 flush miss", 32'h1234_5678, 0, 0);
        load(1, 2'd0, 32'h0100_0000, 32'h0A00_0000, 4'h2);
        check("R2 at base", {ld_ok, ld_slot, lk_base}, {1'b1, 3'd0, 4'd1});
        load(0, 2'd0, 32'h0200_0000, 32'h0B00_0000, 4'h2);
        check("R4 above base", ld_slot, 1);
        load(1, 2'd0, 32'h0300_0000, 32'h0C00_0000, 4'h2);
        check("R2 overwrite base", {ld_slot, lk_base, lk_victim}, {3'd1, 4'd2, 4'd2});
        look("R2 overwritten gone", 32'h0200_0000, 0, 0);
        look("R2 pinned hit", 32'h0300_0040, 1, 32'h0C00_0040);
    endtask

    task automatic t_wrap_base();
        flush();
        load(1, 2'd0, 32'h0100_0000, 32'h0, 4'h0);
        load(1, 2'd0, 32'h0110_0000, 32'h0, 4'h0);
        for (int i = 0; i < 6; i++)
            load(0, 2'd0, 32'h0200_0000 + (i << 20), 32'h0, 4'h0);
        check("R5 wrap to base", {ld_slot, lk_base, lk_victim}, {3'd7, 4'd2, 4'd2});
        inv_req = 1; inv_va = 32'h0100_0000;
        tick();
        look("R8 pinned cleared", 32'h0100_0000, 0, 0);
        load(0, 2'd0, 32'h0400_0000, 32'h0, 4'h0);
        check("R4 full below base", {ld_ok, ld_full}, 2'b01);
        look("R4 full no write", 32'h0400_0000, 0, 0);
        look("R8 neighbour kept", 32'h0110_0000, 1, 32'h0);
    endtask

    task automatic t_full_and_busy();
        flush();
        for (int i = 0; i < 8; i++)
            load(0, 2'd0, (32'(i) + 16) << 20, 32'h0, 4'h0);
        check("R5 wrap zero base", lk_victim, 0);
        load(0, 2'd0, 32'h0F00_0000, 32'h0, 4'h0);
        check("R4 full", {ld_ok, ld_busy, ld_full}, 3'b001);
        check("R4 full lock", {lk_base, lk_victim}, 8'h00);
        rd_req = 1; rd_idx = 5;
        tick();
        check("R10 read 5", rd_va, 32'h0150_0000);
        check("R10 victim 5", lk_victim, 5);
        flush();
        for (int i = 0; i < 8; i++)
            load(1, 2'd3, 32'(i) << 24, 32'h0, 4'h0);
        check("R3 all pinned", {lk_base, lk_victim}, {4'd8, 4'd8});
        load(0, 2'd0, 32'h0F00_0000, 32'h0, 4'h0);
        check("R3 busy", {ld_ok, ld_busy, ld_full}, 3'b010);
        load(1, 2'd0, 32'h0F00_0000, 32'h0, 4'h0);
        check("R3 busy pinned", {ld_busy, lk_base}, {1'b1, 4'd8});
    endtask

    task automatic t_priority();
        flush();
        load(0, 2'd0, 32'h1230_0000, 32'h8000_0000, 4'h3);
        ld_req = 1; ld_keep = 0; ld_size = 0; ld_va = 32'h0040_0000;
        inv_req = 1; inv_va = 32'h1234_0000;
        tick();
        check("R11 load beats inval", {ld_ok, ld_slot}, {1'b1, 3'd1});
        look("R11 inval dropped", 32'h1234_5678, 1, 32'h8004_5678);
        flush_req = 1; ld_req = 1; ld_va = 32'h0700_0000;
        tick();
        check("R11 flush beats load", {ld_ok, lk_base, lk_victim}, 9'h000);
        look("R11 flush clears", 32'h0700_0000, 0, 0);
        load(0, 2'd0, 32'h1230_0000, 32'h8000_0000, 4'h3);
        rd_req = 1; rd_idx = 0; inv_req = 1; inv_va = 32'h1230_0000;
        tick();
        check("R11 inval beats read", rd_ack, 0);
        look("R11 inval applied", 32'h1234_5678, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_sizes();
        t_inval();
        t_pinned();
        t_wrap_base();
        t_full_and_busy();
        t_priority();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule